// File: doc/BRIEF.md
# Block Parameter Queue for a Variable-Length Check-Symbol Encoder

This block sits in front of a block-code encoder whose code length and number of check symbols may change from one code block to the next. Upstream logic writes one control word per block on a stream channel. Each word carries the block length and, when the check-symbol count is run-time selectable, the number of check symbols. Each of these fields is zero-padded to a whole number of bytes. Words are held in a small queue, so parameters can be written well ahead of the data they govern.

When the first data symbol of a new block is accepted, the block takes the oldest word from the queue. It derives the data-symbol count and presents the total length, the data-symbol count and the check-symbol count to the encoder datapath, along with per-symbol, first-symbol and last-symbol strobes. If no word is waiting at a block boundary, the data input is held off. Every word is compared against limits fixed at build time. A violation raises an error flag that stays set until reset.

A build parameter selects between two modes. In the variable mode, the check-symbol count comes from each word. In the fixed mode, the check-symbol count is a constant and only the length field is present.

Top module: `rsq_ctrl_queue`

## Requirements
- R1: The queue accepts up to DEPTH (default 16) control words while no symbol is taken. `ctrl_ready` is low whenever DEPTH words are held, and it rises again once a word has been consumed.
- R2: `sym_ready` is high only when `dp_ready` is high and either a block is in progress or at least one word is queued. With an empty queue between blocks, no symbol is accepted.
- R3: Exactly one word is consumed per block, on acceptance of the block's first symbol, and words are used in arrival order. `blk_n`, `blk_k` and `blk_r` change only in a cycle where `blk_first` is high.
- R4: In the variable mode, the length field is `ctrl_data[7:0]` and the check-symbol field is `ctrl_data[12:8]`, inside the byte `[15:8]`. The block then reports `blk_n` = length, `blk_r` = check field and `blk_k` = length − check field.
- R5: Each accepted symbol gives one `blk_sym` pulse in the cycle after acceptance. The block's first pulse carries `blk_first` and its `blk_k`-th pulse carries `blk_end`. A block with `blk_k` = 1 has both strobes on one pulse.
- R6: Pad bits `ctrl_data[15:13]` have no effect on any output.
- R7: A word is out of range when the length is below 4, when the check count is below 2 or above min(CHECK_MAX, R_CAP) (default 16), or when the length is not greater than the check count. Such a word sets `ctrl_bad` in the cycle its block starts.
- R8: `ctrl_bad` stays high until `rst`. An out-of-range word is still consumed, and its block is one symbol long with `blk_k` = 1.
- R9: After reset: `ctrl_ready` = 1, `sym_ready` = 0 with an empty queue, all strobes are 0 and `ctrl_bad` = 0.
- R10: In the fixed mode (VAR_R = 0), `ctrl_data[7:0]` is the length, `blk_r` = CHECK_MAX and `blk_k` = length − CHECK_MAX. A length not greater than CHECK_MAX is out of range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_valid | input | 1 | Control word offered |
| ctrl_ready | output | 1 | Queue has room for a word |
| ctrl_data | input | CTRL_W (16) | Padded length field, plus padded check field in the variable mode |
| sym_valid | input | 1 | Data symbol offered upstream |
| sym_ready | output | 1 | Data symbol may be taken this cycle |
| dp_ready | input | 1 | Encoder datapath can take a symbol |
| blk_sym | output | 1 | Registered pulse per accepted symbol |
| blk_first | output | 1 | Pulse marks a block's first symbol |
| blk_end | output | 1 | Pulse marks a block's last data symbol |
| blk_n | output | SYM_W (8) | Current block length |
| blk_k | output | SYM_W (8) | Current data-symbol count |
| blk_r | output | RW (5) | Current check-symbol count |
| ctrl_bad | output | 1 | Sticky out-of-range flag |

## Verification
The hardest state to reach is a full queue while a producer still offers a word and the consumer then starts. The stimulus reaches it by loading sixteen words with the data input idle, then launching the symbol feeder at the same time as a seventeenth write. That write must hang until the first block starts and must then be used last. Out-of-range words are run one kind per reset, each followed by a valid word, so that stickiness and the one-symbol block are both seen. A second instance built in the fixed mode covers the constant check-symbol path.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

  typedef enum logic {
    TRK_IDLE = 1'b0,
    TRK_BUSY = 1'b1
  } trk_state_e;

  // bits rounded up to the next whole byte
  function automatic int pad_to_byte(input int bits);
    return ((bits + 7) / 8) * 8;
  endfunction

  function automatic int min_int(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

endpackage

// File: rtl/rsq_ctrl_fifo.sv
module rsq_ctrl_fifo #(
  parameter  int WIDTH = 13,
  parameter  int DEPTH = 16,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             full,
  output logic             empty
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr;
  logic [AW-1:0]    rd_ptr;
  logic [CW-1:0]    count;

  function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // storage without reset so it maps to distributed RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_en) wr_ptr <= next_ptr(wr_ptr);
      if (rd_en) rd_ptr <= next_ptr(rd_ptr);
      case ({wr_en, rd_en})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign rd_data = mem[rd_ptr];
  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);

endmodule

// File: rtl/rsq_cfg_decode.sv
module rsq_cfg_decode
  import rsq_pkg::*;
#(
  parameter  int SYM_W     = 8,
  parameter  int RW        = 5,
  parameter  int CHECK_MAX = 16,
  parameter  int R_CAP     = 128,
  parameter  int VAR_R     = 1,
  parameter  int FW        = 13,
  localparam int R_HI      = min_int(CHECK_MAX, R_CAP)
) (
  input  logic [FW-1:0]    entry,
  output logic [SYM_W-1:0] cfg_n,
  output logic [SYM_W-1:0] cfg_k,
  output logic [RW-1:0]    cfg_r,
  output logic             cfg_bad
);

  logic [SYM_W-1:0] n_fld;
  logic [RW-1:0]    r_fld;
  logic             bad_w;

  assign n_fld = entry[SYM_W-1:0];

  generate
    if (VAR_R != 0) begin : g_var
      assign r_fld = entry[SYM_W +: RW];
      assign bad_w = (n_fld < SYM_W'(4))
                  || (r_fld < RW'(2))
                  || (r_fld > RW'(R_HI))
                  || (n_fld <= SYM_W'(r_fld));
    end else begin : g_fix
      assign r_fld = RW'(CHECK_MAX);
      assign bad_w = (n_fld < SYM_W'(4))
                  || (n_fld <= SYM_W'(CHECK_MAX));
    end
  endgenerate

  // an out-of-range word is turned into a one-symbol block
  assign cfg_n   = n_fld;
  assign cfg_r   = r_fld;
  assign cfg_bad = bad_w;
  assign cfg_k   = bad_w ? SYM_W'(1) : (n_fld - SYM_W'(r_fld));

endmodule

// File: rtl/rsq_blk_track.sv
module rsq_blk_track
  import rsq_pkg::*;
#(
  parameter int SYM_W = 8,
  parameter int RW    = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sym_valid,
  input  logic             dp_ready,
  input  logic             have_word,
  input  logic [SYM_W-1:0] cfg_n,
  input  logic [SYM_W-1:0] cfg_k,
  input  logic [RW-1:0]    cfg_r,
  input  logic             cfg_bad,
  output logic             sym_ready,
  output logic             pop,
  output logic             busy,
  output logic             blk_sym,
  output logic             blk_first,
  output logic             blk_end,
  output logic [SYM_W-1:0] blk_n,
  output logic [SYM_W-1:0] blk_k,
  output logic [RW-1:0]    blk_r,
  output logic             ctrl_bad
);

  trk_state_e       state;
  logic [SYM_W-1:0] rem;
  logic             fire;
  logic             last_now;

  assign busy      = (state == TRK_BUSY);
  assign sym_ready = dp_ready && (busy || have_word);
  assign fire      = sym_valid && sym_ready;
  assign pop       = fire && !busy;
  assign last_now  = busy ? (rem == SYM_W'(1)) : (cfg_k == SYM_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= TRK_IDLE;
      rem       <= '0;
      blk_sym   <= 1'b0;
      blk_first <= 1'b0;
      blk_end   <= 1'b0;
      blk_n     <= '0;
      blk_k     <= '0;
      blk_r     <= '0;
      ctrl_bad  <= 1'b0;
    end else begin
      blk_sym   <= fire;
      blk_first <= pop;
      blk_end   <= fire && last_now;
      if (pop) begin
        blk_n    <= cfg_n;
        blk_k    <= cfg_k;
        blk_r    <= cfg_r;
        ctrl_bad <= ctrl_bad | cfg_bad;
        rem      <= cfg_k - 1'b1;
        state    <= (cfg_k == SYM_W'(1)) ? TRK_IDLE : TRK_BUSY;
      end else if (fire) begin
        rem <= rem - 1'b1;
        if (rem == SYM_W'(1)) state <= TRK_IDLE;
      end
    end
  end

endmodule

// File: rtl/rsq_ctrl_queue.sv
module rsq_ctrl_queue
  import rsq_pkg::*;
#(
  parameter  int SYM_W     = 8,
  parameter  int CHECK_MAX = 16,
  parameter  int R_CAP     = 128,
  parameter  int VAR_R     = 1,
  parameter  int DEPTH     = 16,
  localparam int RW        = $clog2(CHECK_MAX + 1),
  localparam int PN        = pad_to_byte(SYM_W),
  localparam int PR        = pad_to_byte(RW),
  localparam int CTRL_W    = PN + ((VAR_R != 0) ? PR : 0),
  localparam int FW        = SYM_W + ((VAR_R != 0) ? RW : 0)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_valid,
  output logic              ctrl_ready,
  input  logic [CTRL_W-1:0] ctrl_data,
  input  logic              sym_valid,
  output logic              sym_ready,
  input  logic              dp_ready,
  output logic              blk_sym,
  output logic              blk_first,
  output logic              blk_end,
  output logic [SYM_W-1:0]  blk_n,
  output logic [SYM_W-1:0]  blk_k,
  output logic [RW-1:0]     blk_r,
  output logic              ctrl_bad
);

  logic [FW-1:0]    fifo_wr_data;
  logic [FW-1:0]    fifo_rd_data;
  logic             fifo_full;
  logic             fifo_empty;
  logic             fifo_wr;
  logic             pop;
  logic             trk_busy;
  logic [SYM_W-1:0] cfg_n;
  logic [SYM_W-1:0] cfg_k;
  logic [RW-1:0]    cfg_r;
  logic             cfg_bad;
  logic             unused_pad;

  // keep only the meaningful field bits; padding is dropped at the edge
  generate
    if (VAR_R != 0) begin : g_pack_var
      assign fifo_wr_data = {ctrl_data[PN +: RW], ctrl_data[SYM_W-1:0]};
    end else begin : g_pack_fix
      assign fifo_wr_data = ctrl_data[SYM_W-1:0];
    end
  endgenerate
  assign unused_pad = ^ctrl_data;

  assign ctrl_ready = !fifo_full;
  assign fifo_wr    = ctrl_valid && !fifo_full;

  rsq_ctrl_fifo #(
    .WIDTH (FW),
    .DEPTH (DEPTH)
  ) u_fifo (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (fifo_wr),
    .wr_data (fifo_wr_data),
    .rd_en   (pop),
    .rd_data (fifo_rd_data),
    .full    (fifo_full),
    .empty   (fifo_empty)
  );

  rsq_cfg_decode #(
    .SYM_W     (SYM_W),
    .RW        (RW),
    .CHECK_MAX (CHECK_MAX),
    .R_CAP     (R_CAP),
    .VAR_R     (VAR_R),
    .FW        (FW)
  ) u_dec (
    .entry   (fifo_rd_data),
    .cfg_n   (cfg_n),
    .cfg_k   (cfg_k),
    .cfg_r   (cfg_r),
    .cfg_bad (cfg_bad)
  );

  rsq_blk_track #(
    .SYM_W (SYM_W),
    .RW    (RW)
  ) u_trk (
    .clk       (clk),
    .rst       (rst),
    .sym_valid (sym_valid),
    .dp_ready  (dp_ready),
    .have_word (!fifo_empty),
    .cfg_n     (cfg_n),
    .cfg_k     (cfg_k),
    .cfg_r     (cfg_r),
    .cfg_bad   (cfg_bad),
    .sym_ready (sym_ready),
    .pop       (pop),
    .busy      (trk_busy),
    .blk_sym   (blk_sym),
    .blk_first (blk_first),
    .blk_end   (blk_end),
    .blk_n     (blk_n),
    .blk_k     (blk_k),
    .blk_r     (blk_r),
    .ctrl_bad  (ctrl_bad)
  );

endmodule

// File: rtl/rsq_ctrl_queue_chk.sv
module rsq_ctrl_queue_chk #(
  parameter  int SYM_W = 8,
  parameter  int RW    = 5,
  parameter  int DEPTH = 16,
  parameter  int R_HI  = 16,
  localparam int OW    = $clog2(DEPTH + 1) + 1
) (
  input logic             clk,
  input logic             rst,
  input logic             ctrl_valid,
  input logic             ctrl_ready,
  input logic             sym_ready,
  input logic             dp_ready,
  input logic             trk_busy,
  input logic             pop,
  input logic             blk_sym,
  input logic             blk_first,
  input logic             blk_end,
  input logic [SYM_W-1:0] blk_n,
  input logic [SYM_W-1:0] blk_k,
  input logic [RW-1:0]    blk_r,
  input logic             ctrl_bad
);

  logic [OW-1:0] occ;
  logic          in_blk;

  // independent occupancy from handshakes seen at the edges
  always_ff @(posedge clk) begin
    if (rst) begin
      occ    <= '0;
      in_blk <= 1'b0;
    end else begin
      occ <= occ + OW'(ctrl_valid && ctrl_ready) - OW'(pop);
      if (blk_sym) in_blk <= !blk_end;
    end
  end

  AST_QUEUE_BOUND: assert property (@(posedge clk) disable iff (rst)
    occ <= OW'(DEPTH)); // R1
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (occ == OW'(DEPTH)) |-> !ctrl_ready); // R1
  AST_STALL_EMPTY: assert property (@(posedge clk) disable iff (rst)
    sym_ready |-> (dp_ready && (trk_busy || occ != '0))); // R2
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !blk_first |-> ($stable(blk_n) && $stable(blk_k) && $stable(blk_r))); // R3
  AST_K_PLUS_R: assert property (@(posedge clk) disable iff (rst)
    (blk_first && !ctrl_bad) |->
      ((SYM_W+1)'(blk_k) + (SYM_W+1)'(blk_r) == (SYM_W+1)'(blk_n))); // R4
  AST_FIRST_IDLE: assert property (@(posedge clk) disable iff (rst)
    blk_first |-> !in_blk); // R5
  AST_SYM_INSIDE: assert property (@(posedge clk) disable iff (rst)
    (blk_sym && !blk_first) |-> in_blk); // R5
  AST_STROBE_SYM: assert property (@(posedge clk) disable iff (rst)
    (blk_first || blk_end) |-> blk_sym); // R5
  AST_R_LIMITS: assert property (@(posedge clk) disable iff (rst)
    (blk_first && !ctrl_bad) |-> (blk_r >= RW'(2) && blk_r <= RW'(R_HI))); // R7
  AST_BAD_STICKY: assert property (@(posedge clk) disable iff (rst)
    ctrl_bad |=> ctrl_bad); // R8
  AST_BAD_ONE_SYM: assert property (@(posedge clk) disable iff (rst)
    (blk_first && $rose(ctrl_bad)) |-> (blk_k == SYM_W'(1) && blk_end)); // R8

endmodule

bind rsq_ctrl_queue rsq_ctrl_queue_chk #(
  .SYM_W (SYM_W),
  .RW    (RW),
  .DEPTH (DEPTH),
  .R_HI  ((VAR_R != 0) ? ((CHECK_MAX < R_CAP) ? CHECK_MAX : R_CAP) : CHECK_MAX)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ctrl_valid (ctrl_valid),
  .ctrl_ready (ctrl_ready),
  .sym_ready  (sym_ready),
  .dp_ready   (dp_ready),
  .trk_busy   (trk_busy),
  .pop        (pop),
  .blk_sym    (blk_sym),
  .blk_first  (blk_first),
  .blk_end    (blk_end),
  .blk_n      (blk_n),
  .blk_k      (blk_k),
  .blk_r      (blk_r),
  .ctrl_bad   (ctrl_bad)
);

// File: tb/tb_rsq_ctrl_queue.sv
module tb_rsq_ctrl_queue;

  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic        rst = 1'b1;
  logic        cv = 1'b0, cr;
  logic [15:0] cd = '0;
  logic        sv = 1'b0, sr, dr = 1'b1;
  logic        bs, bf, be, bad;
  logic [7:0]  bn, bk;
  logic [4:0]  br;

  logic        fcv = 1'b0, fcr;
  logic [7:0]  fcd = '0;
  logic        fsv = 1'b0, fsr, fdr = 1'b1;
  logic        fbs, fbf, fbe, fbad;
  logic [7:0]  fbn, fbk;
  logic [4:0]  fbr;

  rsq_ctrl_queue dut (
    .clk(clk), .rst(rst), .ctrl_valid(cv), .ctrl_ready(cr), .ctrl_data(cd),
    .sym_valid(sv), .sym_ready(sr), .dp_ready(dr), .blk_sym(bs),
    .blk_first(bf), .blk_end(be), .blk_n(bn), .blk_k(bk), .blk_r(br),
    .ctrl_bad(bad));

  rsq_ctrl_queue #(.VAR_R(0), .DEPTH(4)) dut_fix (
    .clk(clk), .rst(rst), .ctrl_valid(fcv), .ctrl_ready(fcr), .ctrl_data(fcd),
    .sym_valid(fsv), .sym_ready(fsr), .dp_ready(fdr), .blk_sym(fbs),
    .blk_first(fbf), .blk_end(fbe), .blk_n(fbn), .blk_k(fbk), .blk_r(fbr),
    .ctrl_bad(fbad));

  typedef struct {
    int    n;
    int    k;
    int    r;
    bit    bad;
    bit    inv;
    string tag;
  } exp_t;

  exp_t        expq[$];
  int          checks = 0, errors = 0;
  int          blocks_done = 0;
  int          cnt = 0, curk = 0;
  bit          sticky = 1'b0;
  logic [15:0] lf = 16'hACE1;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  // driver: offer one word and record what the scoreboard should see
  task automatic push(input int n, input int r, input bit padfill);
    bit   inv;
    exp_t e;
    inv    = (n < 4) || (r < 2) || (r > 16) || (n <= r);
    sticky = sticky | inv;
    e.n = n; e.r = r; e.k = inv ? 1 : n - r;
    e.bad = sticky; e.inv = inv;
    e.tag = inv ? "R8" : (padfill ? "R6" : "R4");
    expq.push_back(e);
    cd        = '0;
    cd[7:0]   = 8'(n);
    cd[12:8]  = 5'(r);
    cd[15:13] = padfill ? 3'b111 : 3'b000;
    cv = 1'b1;
    @(negedge clk);
    while (!cr) @(negedge clk);
    @(posedge clk); #1;
    cv = 1'b0;
    cd = 16'hFFFF;
  endtask

  task automatic feed(input bit rnd, input int target);
    while (blocks_done < target) begin
      @(posedge clk); #1;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      sv = rnd ? (lf[0] | lf[3]) : 1'b1;
      dr = rnd ? (lf[5] | lf[8]) : 1'b1;
    end
    sv = 1'b0;
    dr = 1'b1;
  endtask

  task automatic do_reset();
    rst = 1'b1; sv = 1'b0; cv = 1'b0; fsv = 1'b0; fcv = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    sticky = 1'b0;
    expq.delete();
  endtask

  // monitor: pops the scoreboard at each block start, checks length at end
  always @(negedge clk) begin
    if (!rst && bs) begin
      if (bf) begin
        if (expq.size() == 0) begin
          check(1'b0, "R3", "block without queued word", 1, 0);
        end else begin
          exp_t e;
          e = expq.pop_front();
          curk = e.k;
          cnt  = 1;
          check(bn == 8'(e.n), e.tag, "blk_n", int'(bn), e.n);
          check(bk == 8'(e.k), e.tag, "blk_k", int'(bk), e.k);
          if (!e.inv) check(br == 5'(e.r), e.tag, "blk_r", int'(br), e.r);
          check(bad == e.bad, e.inv ? "R7" : "R8", "ctrl_bad", int'(bad), int'(e.bad));
        end
      end else begin
        cnt++;
      end
      if (be) begin
        check(cnt == curk, "R5", "symbols in block", cnt, curk);
        blocks_done++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int target;
    int cntf;
    int kn[4] = '{3, 20, 40, 10};
    int kr[4] = '{2, 1, 17, 10};

    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(cr == 1'b1, "R9", "ctrl_ready after reset", int'(cr), 1);
    check(sr == 1'b0, "R9", "sym_ready after reset", int'(sr), 0);
    check(bs == 1'b0 && bf == 1'b0 && be == 1'b0, "R9", "strobes", int'(bs), 0);
    check(bad == 1'b0, "R9", "ctrl_bad after reset", int'(bad), 0);

    // R2: empty queue holds off the data input
    sv = 1'b1; dr = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check(sr == 1'b0, "R2", "sym_ready with empty queue", int'(sr), 0);
      check(bs == 1'b0, "R2", "symbol taken with empty queue", int'(bs), 0);
    end
    sv = 1'b0;
    @(posedge clk); #1;

    // R1: fill the queue with no data moving
    for (int i = 0; i < 16; i++) begin
      int r, n;
      r = 2 + (i * 5) % 15;
      n = (i == 15) ? 255 : r + 2 + (i * 29) % 60;
      push(n, r, i[0]);
    end
    @(negedge clk);
    check(cr == 1'b0, "R1", "ctrl_ready with full queue", int'(cr), 0);
    @(posedge clk); #1;

    // R1/R3: seventeenth word waits for the first block to start
    target = blocks_done + 17;
    fork
      feed(1'b0, target);
      push(60, 9, 1'b0);
    join
    check(expq.size() == 0, "R3", "words left after run", expq.size(), 0);

    // random stalls with short and boundary blocks
    target = blocks_done + 6;
    fork
      begin
        push(5, 4, 1'b0);
        push(4, 3, 1'b1);
        push(4, 2, 1'b0);
        push(255, 2, 1'b1);
        push(40, 16, 1'b0);
        push(18, 7, 1'b1);
      end
      feed(1'b1, target);
    join
    check(expq.size() == 0, "R3", "words left after random run", expq.size(), 0);

    // R2: datapath not ready blocks acceptance even with a word queued
    dr = 1'b0; sv = 1'b1;
    @(negedge clk);
    check(sr == 1'b0, "R2", "sym_ready empty and stalled", int'(sr), 0);
    @(posedge clk); #1;
    push(30, 6, 1'b0);
    @(negedge clk);
    check(sr == 1'b0, "R2", "sym_ready with dp_ready low", int'(sr), 0);
    dr = 1'b1;
    #1;
    check(sr == 1'b1, "R2", "sym_ready with word and dp_ready", int'(sr), 1);
    feed(1'b0, blocks_done + 1);

    // R7/R8: each out-of-range kind, then a valid word
    for (int j = 0; j < 4; j++) begin
      do_reset();
      @(negedge clk);
      check(bad == 1'b0, "R8", "ctrl_bad cleared by reset", int'(bad), 0);
      @(posedge clk); #1;
      push(kn[j], kr[j], 1'b0);
      push(30, 5, 1'b0);
      feed(1'b0, blocks_done + 2);
      @(negedge clk);
      check(bad == 1'b1, "R8", "ctrl_bad held", int'(bad), 1);
    end

    // R10: fixed check-symbol mode
    do_reset();
    fcd = 8'd20; fcv = 1'b1;
    @(negedge clk);
    while (!fcr) @(negedge clk);
    @(posedge clk); #1;
    fcv = 1'b0;
    fsv = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(fbf == 1'b1, "R10", "first strobe", int'(fbf), 1);
    check(fbn == 8'd20, "R10", "blk_n", int'(fbn), 20);
    check(fbk == 8'd4, "R10", "blk_k", int'(fbk), 4);
    check(fbr == 5'd16, "R10", "blk_r", int'(fbr), 16);
    check(fbad == 1'b0, "R10", "ctrl_bad", int'(fbad), 0);
    cntf = 1;
    for (int t = 0; t < 20 && !fbe; t++) begin
      @(negedge clk);
      if (fbs) cntf++;
    end
    fsv = 1'b0;
    check(cntf == 4, "R10", "symbols in block", cntf, 4);
    @(posedge clk); #1;
    fcd = 8'd16; fcv = 1'b1;
    @(negedge clk);
    while (!fcr) @(negedge clk);
    @(posedge clk); #1;
    fcv = 1'b0;
    fsv = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(fbad == 1'b1, "R10", "length not above check count", int'(fbad), 1);
    check(fbk == 8'd1 && fbe == 1'b1, "R10", "one-symbol block", int'(fbk), 1);
    fsv = 1'b0;

    repeat (2) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule